// File: doc/BRIEF.md
# Shared sprite and sample DMA controller

This block is the single bus master inside a processor-plus-audio chip. It serves two clients. The first is a page copier: a CPU write of a page number to the copy register starts a transfer of that whole 256-byte memory page into sprite memory. Each byte is read from the system bus and written to the sprite write port in the next cycle. The second client is a one-byte sample fetch, which an audio channel asks for when its buffer runs empty.

To own the bus, the block pulls the CPU ready line low and turns off the CPU's address and data drivers. A free-running get/put phase bit orders the work: copy reads fall on get cycles and sprite writes fall on put cycles. A sample fetch may borrow the next free copy read slot. Because of this, the length of the stall depends on the cycle in which the sample request arrives.

When no copy is running, a sample fetch waits out any CPU write burst before it drives the sample address. The CPU only honours a low ready during its read cycles.

Top module: `shared_dma_ctrl`

## Requirements
- R1: After reset, `rdy_out` is 1, `dma_active` is 0, and `dma_rd_en`, `oam_wr_en` and `dmc_data_valid` are all 0.
- R2: A phase bit is cleared by reset and toggles every clock. The first cycle after reset is put (phase 0), and get cycles have phase 1. Copy reads happen only on get cycles and sprite writes only on put cycles.
- R3: A copy starts only on a cycle with `cpu_write_strobe`=1, `reg_sel`=1 and `cpu_rw`=0, taking page P from `cpu_data`. A strobe with `cpu_rw`=1, or with `reg_sel`=0, leaves `rdy_out` high. The copy reads addresses {P, i} for i = 0 to 255 in order. Each byte read appears on `oam_wr_data` with `oam_wr_en`=1 in the following cycle.
- R4: A copy with no sample request holds `rdy_out` low for 513 cycles when the trigger cycle has phase 1, and for 514 cycles when it has phase 0. The low period starts in the cycle after the trigger.
- R5: A sample request is accepted only on a cycle where `dmc_enable & dmc_req` rises. While `dmc_enable`=0, `dmc_req` causes no stall and no fetch.
- R6: With no copy running, an accepted sample request holds `rdy_out` low for 4 cycles if `cpu_rw`=1 in the request cycle, and for 3 cycles if `cpu_rw`=0. The read of `dmc_addr` happens in the last of those low cycles.
- R7: A sample request that arrives in the copy trigger cycle, or in any later copy cycle up to and including the write of byte 253, takes the next get slot ahead of the copy read. This lengthens the copy by exactly 2 cycles.
- R8: A sample request that arrives in the write cycle of byte 254 (the copy's third-from-last cycle) lengthens the copy by 1 cycle. The sample is read in the cycle after the final sprite write.
- R9: A sample request that arrives in the copy's final cycle (the write of byte 255) lengthens the stall by 3 cycles.
- R10: Each sample read raises `dmc_data_valid` for exactly one cycle, in the cycle after the read. In that cycle `dmc_data_out` holds the byte read at `dmc_addr`. Copied sprite bytes are unaffected by an interleaved fetch.
- R11: `rdy_out` returns high in the cycle after the last DMA bus access, and `dma_active` is always the inverse of `rdy_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rw | input | 1 | CPU cycle type, 1 = read, 0 = write |
| cpu_write_strobe | input | 1 | CPU register write strobe |
| reg_sel | input | 1 | Copy register addressed |
| cpu_data | input | DATA_W | CPU write data (page number) |
| rdy_out | output | 1 | CPU ready, low while DMA owns the bus |
| dma_active | output | 1 | Disables CPU address/data drivers |
| dma_addr | output | ADDR_W | DMA read address |
| dma_rd_en | output | 1 | DMA read this cycle |
| bus_data_in | input | DATA_W | Read data from system bus |
| oam_wr_en | output | 1 | Sprite memory write strobe |
| oam_wr_data | output | DATA_W | Sprite memory write data |
| dmc_enable | input | 1 | Audio channel enabled |
| dmc_req | input | 1 | Audio channel buffer empty |
| dmc_addr | input | ADDR_W | Sample address to fetch |
| dmc_data_out | output | DATA_W | Fetched sample byte |
| dmc_data_valid | output | 1 | One-cycle strobe for `dmc_data_out` |

## Verification
The assertions rely on a few conditions about the inputs:
- The audio channel keeps `dmc_req` high until it sees `dmc_data_valid`, and drops it right after.
- `dmc_addr` stays stable while a fetch is pending.
- Copy triggers are issued only while `rdy_out` is high.

The stimulus respects all of these. It drops the request at the valid pulse, holds the sample address constant, and starts each copy or standalone fetch only after the previous stall has ended. Random page numbers, random idle gaps (which change the trigger phase) and random request offsets inside a copy are mixed with directed requests at the trigger cycle and at the last three copy cycles.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HALT,
      ST_ALIGN,
      ST_GET,
      ST_PUT,
      ST_SWAIT,
      ST_SREAD
   } sdc_state_e;
endpackage

// File: rtl/sdc_phase.sv
module sdc_phase (
   input  logic clk,
   input  logic rst_n,
   output logic get_ph
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) get_ph <= 1'b0;
      else        get_ph <= ~get_ph;
   end
endmodule

// File: rtl/sdc_req.sv
module sdc_req (
   input  logic clk,
   input  logic rst_n,
   input  logic dmc_enable,
   input  logic dmc_req,
   input  logic served,
   output logic req_rise,
   output logic pend
);
   logic want, want_q;

   assign want     = dmc_enable & dmc_req;
   assign req_rise = want & ~want_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         want_q <= 1'b0;
         pend   <= 1'b0;
      end else begin
         want_q <= want;
         if (req_rise)    pend <= 1'b1;
         else if (served) pend <= 1'b0;
      end
   end

   AST_FETCH_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      served |-> pend) else $error("fetch without pending request"); // R5
endmodule

// File: rtl/sdc_seq.sv
module sdc_seq
   import sdc_pkg::*;
#(
   parameter int OFS_W   = 8,
   parameter int WAIT_RD = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig,
   input  logic             cpu_rw,
   input  logic             get_ph,
   input  logic             req_rise,
   input  logic             pend,
   output logic             idle,
   output logic             accept,
   output logic             cp_rd,
   output logic             cp_wr,
   output logic             smp_rd,
   output logic [OFS_W-1:0] idx
);
   localparam int CNT_W = $clog2(WAIT_RD);
   localparam logic [CNT_W-1:0] LD_RD = CNT_W'(WAIT_RD - 1);
   localparam logic [CNT_W-1:0] LD_WR = CNT_W'(WAIT_RD - 2);

   sdc_state_e       st;
   logic             put_valid;
   logic [CNT_W-1:0] wcnt;
   logic             last_idx, steal, fin;

   assign idle     = (st == ST_IDLE);
   assign accept   = idle & trig;
   assign last_idx = &idx;
   assign steal    = (st == ST_GET) & pend & ~last_idx;
   assign cp_rd    = (st == ST_GET) & ~steal;
   assign smp_rd   = (st == ST_SREAD) | steal;
   assign cp_wr    = (st == ST_PUT) & put_valid;
   assign fin      = cp_wr & last_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         idx       <= '0;
         put_valid <= 1'b0;
         wcnt      <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (trig) begin
                  st  <= ST_HALT;
                  idx <= '0;
               end else if (req_rise || pend) begin
                  st   <= ST_SWAIT;
                  wcnt <= cpu_rw ? LD_RD : LD_WR;
               end
            end
            ST_HALT:  st <= get_ph ? ST_ALIGN : ST_GET;
            ST_ALIGN: st <= ST_GET;
            ST_GET: begin
               put_valid <= cp_rd;
               st        <= ST_PUT;
            end
            ST_PUT: begin
               if (cp_wr) idx <= idx + 1'b1;
               if (fin) begin
                  if (pend) st <= ST_SREAD;
                  else if (req_rise) begin
                     st   <= ST_SWAIT;
                     wcnt <= LD_WR;
                  end else st <= ST_IDLE;
               end else st <= ST_GET;
            end
            ST_SWAIT: begin
               if (wcnt == '0) st <= ST_SREAD;
               else            wcnt <= wcnt - 1'b1;
            end
            ST_SREAD: st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   AST_GET_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_GET) |-> get_ph) else $error("copy read off get phase"); // R2
   AST_PUT_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PUT) |-> !get_ph) else $error("copy write off put phase"); // R2
endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic [OFS_W-1:0]  idx,
   input  logic              cp_rd,
   input  logic              cp_wr,
   input  logic              smp_rd,
   input  logic [ADDR_W-1:0] dmc_addr,
   input  logic [DATA_W-1:0] bus_data_in,
   output logic [ADDR_W-1:0] dma_addr,
   output logic              dma_rd_en,
   output logic              oam_wr_en,
   output logic [DATA_W-1:0] oam_wr_data,
   output logic [DATA_W-1:0] dmc_data_out,
   output logic              dmc_data_valid
);
   localparam int PAGE_W = ADDR_W - OFS_W;

   logic [PAGE_W-1:0] page_q;
   logic [DATA_W-1:0] byte_q;

   assign dma_addr    = smp_rd ? dmc_addr : {page_q, idx};
   assign dma_rd_en   = cp_rd | smp_rd;
   assign oam_wr_en   = cp_wr;
   assign oam_wr_data = byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q         <= '0;
         byte_q         <= '0;
         dmc_data_out   <= '0;
         dmc_data_valid <= 1'b0;
      end else begin
         if (accept) page_q <= cpu_data[PAGE_W-1:0];
         if (cp_rd)  byte_q <= bus_data_in;
         if (smp_rd) dmc_data_out <= bus_data_in;
         dmc_data_valid <= smp_rd;
      end
   end

   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(dma_rd_en && oam_wr_en)) else $error("read and write in one cycle"); // R3
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dmc_data_valid |=> !dmc_data_valid) else $error("valid longer than a cycle"); // R10
endmodule

// File: rtl/shared_dma_ctrl.sv
module shared_dma_ctrl #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 16,
   parameter int OFS_W   = 8,
   parameter int WAIT_RD = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rw,
   input  logic              cpu_write_strobe,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] cpu_data,
   output logic              rdy_out,
   output logic              dma_active,
   output logic [ADDR_W-1:0] dma_addr,
   output logic              dma_rd_en,
   input  logic [DATA_W-1:0] bus_data_in,
   output logic              oam_wr_en,
   output logic [DATA_W-1:0] oam_wr_data,
   input  logic              dmc_enable,
   input  logic              dmc_req,
   input  logic [ADDR_W-1:0] dmc_addr,
   output logic [DATA_W-1:0] dmc_data_out,
   output logic              dmc_data_valid
);
   localparam int PAGE_W = ADDR_W - OFS_W;

   if (PAGE_W < 1 || PAGE_W > DATA_W) begin : g_bad_page
      $error("page field must fit in cpu_data");
   end
   if (WAIT_RD < 2) begin : g_bad_wait
      $error("WAIT_RD must be at least 2");
   end

   logic             get_ph, req_rise, pend, idle, accept;
   logic             cp_rd, cp_wr, smp_rd, trig;
   logic [OFS_W-1:0] idx;

   assign trig       = cpu_write_strobe & reg_sel & ~cpu_rw;
   assign rdy_out    = idle;
   assign dma_active = ~idle;

   sdc_phase u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .get_ph (get_ph)
   );

   sdc_req u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .dmc_enable (dmc_enable),
      .dmc_req    (dmc_req),
      .served     (smp_rd),
      .req_rise   (req_rise),
      .pend       (pend)
   );

   sdc_seq #(.OFS_W(OFS_W), .WAIT_RD(WAIT_RD)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig),
      .cpu_rw   (cpu_rw),
      .get_ph   (get_ph),
      .req_rise (req_rise),
      .pend     (pend),
      .idle     (idle),
      .accept   (accept),
      .cp_rd    (cp_rd),
      .cp_wr    (cp_wr),
      .smp_rd   (smp_rd),
      .idx      (idx)
   );

   sdc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dp (
      .clk            (clk),
      .rst_n          (rst_n),
      .accept         (accept),
      .cpu_data       (cpu_data),
      .idx            (idx),
      .cp_rd          (cp_rd),
      .cp_wr          (cp_wr),
      .smp_rd         (smp_rd),
      .dmc_addr       (dmc_addr),
      .bus_data_in    (bus_data_in),
      .dma_addr       (dma_addr),
      .dma_rd_en      (dma_rd_en),
      .oam_wr_en      (oam_wr_en),
      .oam_wr_data    (oam_wr_data),
      .dmc_data_out   (dmc_data_out),
      .dmc_data_valid (dmc_data_valid)
   );

   AST_BUS_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_rd_en || oam_wr_en) |-> !rdy_out) else $error("bus access while ready"); // R11
   AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_out) |-> $past(dma_rd_en || oam_wr_en)) else $error("ready rose without access"); // R11
   AST_VALID_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      dmc_data_valid |-> $past(dma_rd_en && (dma_addr == dmc_addr))) else $error("valid without sample read"); // R10
endmodule

// File: tb/shared_dma_ctrl_tb_top.sv
`timescale 1ns/1ps
module shared_dma_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_rw = 1'b1;
   logic        cpu_write_strobe = 1'b0;
   logic        reg_sel = 1'b0;
   logic [7:0]  cpu_data = '0;
   logic        rdy_out, dma_active, dma_rd_en, oam_wr_en, dmc_data_valid;
   logic [15:0] dma_addr;
   logic [7:0]  bus_data_in, oam_wr_data, dmc_data_out;
   logic        dmc_enable = 1'b0;
   logic        dmc_req = 1'b0;
   logic [15:0] dmc_addr = 16'hC3A7;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   function automatic logic [7:0] mem(input logic [15:0] a);
      return (a[7:0] ^ 8'h5A) + {a[14:8], a[15]};
   endfunction

   assign bus_data_in = mem(dma_addr);

   shared_dma_ctrl dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .cpu_rw           (cpu_rw),
      .cpu_write_strobe (cpu_write_strobe),
      .reg_sel          (reg_sel),
      .cpu_data         (cpu_data),
      .rdy_out          (rdy_out),
      .dma_active       (dma_active),
      .dma_addr         (dma_addr),
      .dma_rd_en        (dma_rd_en),
      .bus_data_in      (bus_data_in),
      .oam_wr_en        (oam_wr_en),
      .oam_wr_data      (oam_wr_data),
      .dmc_enable       (dmc_enable),
      .dmc_req          (dmc_req),
      .dmc_addr         (dmc_addr),
      .dmc_data_out     (dmc_data_out),
      .dmc_data_valid   (dmc_data_valid)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // mode: 0 none, 1 request in trigger cycle, 2 mid copy, 3 third-from-last, 4 last
   task automatic run_copy(input logic [7:0] page, input int mode, input int off_in);
      int n, a, off, expect_len, low, wcnt, bad, phase_bad, vcnt, vbad, sync_bad;
      bit seen_low;
      @(negedge clk);
      n = cyc;
      a = (n % 2 == 1) ? 0 : 1;
      case (mode)
         1: off = 0;
         2: off = off_in % (510 + a);
         3: off = 511 + a;
         4: off = 513 + a;
         default: off = -1;
      endcase
      expect_len = 513 + a + ((mode == 1 || mode == 2) ? 2 : (mode == 3) ? 1 : (mode == 4) ? 3 : 0);
      low = 0; wcnt = 0; bad = 0; phase_bad = 0; vcnt = 0; vbad = 0; sync_bad = 0; seen_low = 0;
      cpu_data = page; cpu_rw = 1'b0; cpu_write_strobe = 1'b1; reg_sel = 1'b1;
      for (int t = 0; t < 2000; t++) begin
         if (t > 0) @(negedge clk);
         if (t == 1) begin
            cpu_write_strobe = 1'b0; reg_sel = 1'b0; cpu_rw = 1'b1;
         end
         if (mode != 0 && t == off) begin
            dmc_enable = 1'b1; dmc_req = 1'b1;
         end
         if (dma_active == rdy_out) sync_bad++;
         if (!rdy_out) begin low++; seen_low = 1; end
         if (oam_wr_en) begin
            if (oam_wr_data != mem({page, wcnt[7:0]})) bad++;
            if ((n + t) % 2 != 0) phase_bad++;
            wcnt++;
         end
         if (dma_rd_en && dma_addr != dmc_addr && (n + t) % 2 != 1) phase_bad++;
         if (dmc_data_valid) begin
            vcnt++;
            if (dmc_data_out != mem(dmc_addr)) vbad++;
            dmc_req = 1'b0;
         end
         if (seen_low && rdy_out) break;
      end
      dmc_enable = 1'b0;
      case (mode)
         0: check(low == expect_len, "R4 copy stall length", low, expect_len);
         1, 2: check(low == expect_len, "R7 copy plus borrowed slot", low, expect_len);
         3: check(low == expect_len, "R8 request on third-from-last", low, expect_len);
         default: check(low == expect_len, "R9 request on last cycle", low, expect_len);
      endcase
      check(wcnt == 256, "R3 sprite write count", wcnt, 256);
      check(bad == 0, "R3 R10 sprite data intact", bad, 0);
      check(phase_bad == 0, "R2 slot phase", phase_bad, 0);
      check(sync_bad == 0, "R11 dma_active inverse", sync_bad, 0);
      check(vcnt == ((mode != 0) ? 1 : 0), "R10 sample valid count", vcnt, (mode != 0) ? 1 : 0);
      check(vbad == 0, "R10 sample data", vbad, 0);
   endtask

   task automatic run_sample(input bit rw);
      int expect_len, low, rd_t, vld_t, vcnt;
      bit seen_low, addr_ok;
      @(negedge clk);
      expect_len = rw ? 4 : 3;
      low = 0; rd_t = -1; vld_t = -1; vcnt = 0; seen_low = 0; addr_ok = 1;
      cpu_rw = rw; dmc_enable = 1'b1; dmc_req = 1'b1;
      for (int t = 0; t < 50; t++) begin
         if (t > 0) @(negedge clk);
         if (t == 1) cpu_rw = 1'b1;
         if (!rdy_out) begin low++; seen_low = 1; end
         if (dma_rd_en) begin
            rd_t = t;
            if (dma_addr != dmc_addr) addr_ok = 0;
         end
         if (dmc_data_valid) begin
            vcnt++; vld_t = t;
            if (dmc_data_out != mem(dmc_addr)) addr_ok = 0;
            dmc_req = 1'b0;
         end
         if (seen_low && rdy_out) break;
      end
      dmc_enable = 1'b0;
      check(low == expect_len, rw ? "R6 stall on read" : "R6 stall on write", low, expect_len);
      check(rd_t == expect_len, "R6 read in last stall cycle", rd_t, expect_len);
      check(vcnt == 1 && vld_t == expect_len + 1, "R10 valid timing", vld_t, expect_len + 1);
      check(addr_ok, "R10 sample address and data", addr_ok, 1);
      check(rdy_out == 1'b1 && vld_t == expect_len + 1, "R11 ready back after access", rdy_out, 1);
   endtask

   task automatic idle_observe(input int cycles, output int low, output int acc);
      low = 0; acc = 0;
      for (int t = 0; t < cycles; t++) begin
         @(negedge clk);
         if (!rdy_out) low++;
         if (dma_rd_en || oam_wr_en || dmc_data_valid) acc++;
      end
   endtask

   initial begin
      int low, acc;
      void'($urandom(32'h5EED1234));
      repeat (4) @(negedge clk);
      check(rdy_out == 1'b1, "R1 ready after reset", rdy_out, 1);
      check(dma_active == 1'b0 && dma_rd_en == 1'b0, "R1 no bus ownership", dma_rd_en, 0);
      check(oam_wr_en == 1'b0 && dmc_data_valid == 1'b0, "R1 outputs quiet", oam_wr_en, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rdy_out == 1'b1, "R1 ready after release", rdy_out, 1);

      // R3: non-qualifying strobes
      cpu_data = 8'h12; cpu_write_strobe = 1'b1; reg_sel = 1'b1; cpu_rw = 1'b1;
      @(negedge clk);
      reg_sel = 1'b0; cpu_rw = 1'b0;
      @(negedge clk);
      cpu_write_strobe = 1'b0; cpu_rw = 1'b1;
      idle_observe(8, low, acc);
      check(low == 0 && acc == 0, "R3 ignored strobe", low, 0);

      // R5: disabled channel
      dmc_enable = 1'b0; dmc_req = 1'b1;
      idle_observe(12, low, acc);
      check(low == 0 && acc == 0, "R5 disabled request", low + acc, 0);
      dmc_req = 1'b0;
      @(negedge clk);

      run_sample(1'b1);
      run_sample(1'b0);

      for (int m = 0; m < 5; m++) begin
         run_copy(8'h40 + m[7:0], m, 137);
         @(negedge clk);
         run_copy(8'h80 + m[7:0], m, 311);
         repeat (2) @(negedge clk);
      end

      for (int i = 0; i < 12; i++) begin
         int gap = $urandom % 4;
         repeat (gap) @(negedge clk);
         run_copy($urandom % 256, $urandom % 5, $urandom % 600);
         repeat (2) @(negedge clk);
      end
      for (int i = 0; i < 6; i++) begin
         repeat ($urandom % 3) @(negedge clk);
         run_sample($urandom % 2);
         @(negedge clk);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule